// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

A last-in first-out store of 64 words, held in flip-flops and addressed by a 6-bit pointer that names the top entry. A push request carries a word in, advances the pointer by one and writes the word into the entry the pointer now names. A pop request copies the word at the pointer into the data register and then steps the pointer back by one. The pointer wraps modulo 64. The first word pushed after reset lands in entry 1 and the sixty-fourth lands in entry 0. Two status bits are both decided by whether the updated pointer equals zero: one says the stack is full, the other says it is empty.

Words enter on a valid/ready channel. A word transfers on a rising clock edge where `push_valid` and `push_ready` are both high. `push_ready` is simply the inverse of the full flag. The channel never stalls: a request seen while `push_ready` is low is rejected at once and flagged, and the producer need not hold it. Pops use a plain request pin, and the popped word appears on `dr_q` one cycle later. Each request that is not allowed leaves every piece of state untouched and raises `err_q` for one cycle. The disallowed cases are a push while full, a pop while empty, and a push together with a pop in the same cycle.

Top module: `regstack_top`

## Requirements
- R1: After reset the pointer is 0, the empty flag is 1, the full flag is 0, `err_q` is 0 and `dr_q` is 0.
- R2: An allowed push moves the pointer from p to (p+1) mod 64 on the clock edge, stores the pushed word in entry (p+1) mod 64, loads that word into `dr_q`, and clears the empty flag.
- R3: The full flag is set exactly when an allowed push leaves the pointer at 0, so it rises on the 64th push after empty. The full flag is never 1 while the pointer is not 0.
- R4: An allowed pop at pointer p loads entry p into `dr_q`, moves the pointer to (p-1) mod 64, and clears the full flag. All of this is visible the cycle after the request.
- R5: The empty flag is set exactly when an allowed pop leaves the pointer at 0. The empty flag is never 1 while the pointer is not 0, and the two flags are never both 1.
- R6: A push while full changes neither the pointer, the flags, the storage nor `dr_q`, and `err_q` is 1 for the next cycle.
- R7: A pop while empty changes neither the pointer, the flags nor `dr_q`, and `err_q` is 1 for the next cycle.
- R8: A push and a pop requested in the same cycle are both discarded with no state change, and `err_q` is 1 for the next cycle.
- R9: Words come back in the reverse of the order they went in, including across a full 64-deep fill and drain.
- R10: `push_ready` is 1 exactly when the full flag is 0. `err_q` is 1 only in the cycle after a rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Push request, with a word on push_data |
| push_ready | output | 1 | High when a push can be taken (not full) |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Pop request |
| dr_q | output | DATA_W | Data register: last pushed or popped word |
| sp_q | output | ADDR_W | Stack pointer, addresses the top entry |
| full_q | output | 1 | Full flag |
| empty_q | output | 1 | Empty flag |
| err_q | output | 1 | One-cycle pulse after a rejected request |

## Verification
A directed fill of 64 pushes followed by a drain of 64 pops checks the exact cycle where the pointer wraps through zero. This pattern separates a flag decided on the updated pointer from one decided on the old pointer, and it exposes a read or write at the wrong entry through the LIFO order of the words. Requests against a full stack, against an empty stack and with both pins high show whether rejection truly freezes the pointer, the flags and the data register. A seeded random mix of pushes, pops, idles and collisions then wanders the pointer across the whole range. In that mix, an off-by-one entry or a flag cleared at the wrong moment shows up as a data or flag mismatch against a bench model.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

  typedef enum logic [1:0] {
    REQ_IDLE   = 2'd0,
    REQ_PUSH   = 2'd1,
    REQ_POP    = 2'd2,
    REQ_REJECT = 2'd3
  } stk_req_e;

  // Decide what a cycle's request does given the current flags.
  function automatic stk_req_e classify_req(input logic push,
                                            input logic pop,
                                            input logic full,
                                            input logic empty);
    stk_req_e r;
    if (push && pop)        r = REQ_REJECT;
    else if (push && full)  r = REQ_REJECT;
    else if (pop && empty)  r = REQ_REJECT;
    else if (push)          r = REQ_PUSH;
    else if (pop)           r = REQ_POP;
    else                    r = REQ_IDLE;
    return r;
  endfunction

endpackage

// File: rtl/regstack_ptr.sv
module regstack_ptr
  import regstack_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              do_push_o,
  output logic              do_pop_o,
  output logic              reject_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sp_up_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);

  localparam logic [ADDR_W-1:0] PTR_ZERO = '0;
  localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PTR_TOP  = '1;

  logic [ADDR_W-1:0] sp_q, sp_up, sp_dn;
  logic              full_q, empty_q, err_q;
  stk_req_e          req;

  assign req   = classify_req(push_i, pop_i, full_q, empty_q);
  assign sp_up = sp_q + PTR_ONE;
  assign sp_dn = sp_q - PTR_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= PTR_ZERO;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (req == REQ_REJECT);
      unique case (req)
        REQ_PUSH: begin
          sp_q    <= sp_up;
          full_q  <= (sp_up == PTR_ZERO);
          empty_q <= 1'b0;
        end
        REQ_POP: begin
          sp_q    <= sp_dn;
          empty_q <= (sp_dn == PTR_ZERO);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign do_push_o = (req == REQ_PUSH);
  assign do_pop_o  = (req == REQ_POP);
  assign reject_o  = (req == REQ_REJECT);
  assign sp_o      = sp_q;
  assign sp_up_o   = sp_up;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;

  // R2: an allowed push advances the pointer by one and clears empty
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_push_o |=> (sp_q == ADDR_W'($past(sp_q) + PTR_ONE)) && !empty_q);

  // R3: the 64th push lands the pointer on zero and raises full
  p_full_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push_o && sp_q == PTR_TOP) |=> full_q);

  // R3: full only while the pointer rests at zero
  p_full_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (sp_q == PTR_ZERO));

  // R4: an allowed pop steps the pointer back and clears full
  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop_o |=> (sp_q == ADDR_W'($past(sp_q) - PTR_ONE)) && !full_q);

  // R5: popping from entry 1 empties the stack
  p_empty_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop_o && sp_q == PTR_ONE) |=> empty_q);

  // R5: flags never both set, empty only at zero
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q) && (!empty_q || sp_q == PTR_ZERO));

  // R6 R7 R8: a rejected request freezes pointer and flags and pulses err
  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |=> $stable(sp_q) && $stable(full_q) && $stable(empty_q) && err_q);

  // R8: a collision is always rejected
  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |-> reject_o);

  // R10: err pulses only after a rejection
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reject_o |=> !err_q);

endmodule

// File: rtl/regstack_mem.sv
module regstack_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_view [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] cell_q;
    logic              hit;
    assign hit = we_i && (waddr_i == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (hit) cell_q <= wdata_i;
    end
    assign word_view[g] = cell_q;
  end

  assign rdata_o = word_view[raddr_i];

endmodule

// File: rtl/regstack_top.sv
module regstack_top #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] dr_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic              full_q,
  output logic              empty_q,
  output logic              err_q
);

  logic              do_push, do_pop, reject;
  logic [ADDR_W-1:0] sp_up;
  logic [DATA_W-1:0] top_word;
  logic [DATA_W-1:0] dr_r;

  regstack_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_valid),
    .pop_i     (pop_req),
    .do_push_o (do_push),
    .do_pop_o  (do_pop),
    .reject_o  (reject),
    .sp_o      (sp_q),
    .sp_up_o   (sp_up),
    .full_o    (full_q),
    .empty_o   (empty_q),
    .err_o     (err_q)
  );

  regstack_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .we_i    (do_push),
    .waddr_i (sp_up),
    .wdata_i (push_data),
    .raddr_i (sp_q),
    .rdata_o (top_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dr_r <= '0;
    else if (do_push) dr_r <= push_data;
    else if (do_pop)  dr_r <= top_word;
  end

  assign dr_q       = dr_r;
  assign push_ready = !full_q;

  // R4: a pop hands the top word to the data register
  p_pop_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (dr_r == $past(top_word)));

  // R2: a push loads the pushed word into the data register
  p_push_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (dr_r == $past(push_data)));

  // R6: rejected request leaves the data register alone
  p_reject_dr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(dr_r));

endmodule

// File: tb/sim_regstack_top.sv
`timescale 1ns/1ps
module sim_regstack_top;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0;
  logic          push_ready;
  logic [DW-1:0] push_data = '0;
  logic          pop_req = 1'b0;
  logic [DW-1:0] dr_q;
  logic [AW-1:0] sp_q;
  logic          full_q, empty_q, err_q;

  always #4 clk = ~clk;

  regstack_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_req(pop_req), .dr_q(dr_q), .sp_q(sp_q),
    .full_q(full_q), .empty_q(empty_q), .err_q(err_q)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench model
  int m_sp;
  bit m_full, m_empty, m_err;
  int m_dr;
  int m_mem [DEPTH];

  function automatic int wrap(input int v);
    return (v + DEPTH) % DEPTH;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model one request; returns its kind for tagging
  task automatic model_step(input bit p, input bit q, input int d, output string tag);
    m_err = 0;
    if (p && q)            begin m_err = 1; tag = "R8"; end
    else if (p && m_full)  begin m_err = 1; tag = "R6"; end
    else if (q && m_empty) begin m_err = 1; tag = "R7"; end
    else if (p) begin
      m_sp = wrap(m_sp + 1); m_mem[m_sp] = d; m_dr = d;
      m_full = (m_sp == 0); m_empty = 0; tag = "R2";
    end else if (q) begin
      m_dr = m_mem[m_sp]; m_sp = wrap(m_sp - 1);
      m_empty = (m_sp == 0); m_full = 0; tag = "R4";
    end else tag = "idle";
  endtask

  task automatic step(input bit p, input bit q, input int d);
    string tag;
    push_valid = p; pop_req = q; push_data = DW'(d);
    @(posedge clk);
    @(negedge clk);
    push_valid = 0; pop_req = 0;
    model_step(p, q, d, tag);
    check(int'(sp_q) == m_sp, {tag, " sp"}, int'(sp_q), m_sp);
    check(int'(dr_q) == m_dr, {tag, " dr R9"}, int'(dr_q), m_dr);
    check(full_q == m_full, {tag, " full R3"}, int'(full_q), int'(m_full));
    check(empty_q == m_empty, {tag, " empty R5"}, int'(empty_q), int'(m_empty));
    check(err_q == m_err, {tag, " err R10"}, int'(err_q), int'(m_err));
    check(push_ready == !m_full, "R10 ready", int'(push_ready), int'(!m_full));
  endtask

  initial begin
    void'($urandom(32'd20250611));
    m_sp = 0; m_full = 0; m_empty = 1; m_dr = 0; m_err = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sp_q == '0, "R1 sp", int'(sp_q), 0);
    check(empty_q == 1'b1, "R1 empty", int'(empty_q), 1);
    check(full_q == 1'b0, "R1 full", int'(full_q), 0);
    check(err_q == 1'b0, "R1 err", int'(err_q), 0);
    check(dr_q == '0, "R1 dr", int'(dr_q), 0);

    // R7 pop on empty, R8 collision on empty
    step(0, 1, 0);
    step(1, 1, 8'h5A);
    // R2/R3 fill all 64 entries; 64th lands at 0
    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'h80 + i);
    check(sp_q == '0 && full_q, "R3 full after 64", int'(sp_q), 0);
    // R6 push while full, twice
    step(1, 0, 8'hEE);
    step(1, 0, 8'hEF);
    // R8 collision while full
    step(1, 1, 8'h11);
    // R4/R5/R9 drain: first pop returns the last pushed word from entry 0
    step(0, 1, 0);
    check(int'(dr_q) == 8'h80 + DEPTH - 1, "R9 first out", int'(dr_q), 8'h80 + DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) step(0, 1, 0);
    check(empty_q && int'(dr_q) == 8'h80, "R5 R9 last out", int'(dr_q), 8'h80);
    step(0, 1, 0);
    // collision while partly filled
    step(1, 0, 8'h33); step(1, 0, 8'h44);
    step(1, 1, 8'h55);
    step(0, 1, 0);
    check(int'(dr_q) == 8'h44, "R8 R9 no push on collision", int'(dr_q), 8'h44);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(99, 0));
      int d = int'($urandom_range(255, 0));
      // bias toward pushes in the first half to reach full
      if (n < 2000) begin
        if (r < 55)      step(1, 0, d);
        else if (r < 90) step(0, 1, 0);
        else if (r < 95) step(1, 1, d);
        else             step(0, 0, 0);
      end else begin
        if (r < 40)      step(1, 0, d);
        else if (r < 88) step(0, 1, 0);
        else if (r < 94) step(1, 1, d);
        else             step(0, 0, 0);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule